// File: doc/BRIEF.md
# Data Transfer Timeout Monitor

This block sits beside an asynchronous parallel bus and watches each data transfer. When a transfer starts and no slave answers in time, the block pulls the bus error line so the master can abort the transfer instead of waiting forever. The same line tells other masters that the empty address was released.

A transfer counts as started only when the address strobe and at least one data strobe are low at the same time. Time spent before that point is never counted. This includes waiting for bus ownership and address-only phases. Every transfer gets its own full time budget.

All bus inputs are active low and asynchronous to the block clock, so each one passes through a two-flop synchronizer. The limit in clock cycles is the product of two parameters: the clock frequency in MHz and the timeout in microseconds.

Top module: `bto_monitor`

## Requirements
- R1: During and straight after reset, `berr_n` is high (1).
- R2: A transfer starts only while `as_n` is 0 and at least one of `ds0_n` or `ds1_n` is 0. Holding `as_n` low with both data strobes high, or a data strobe low with `as_n` high, never makes `berr_n` go low, however long it lasts.
- R3: Any time spent with all strobes high adds nothing toward a timeout. This covers bus arbitration delay.
- R4: The limit is LIMIT = CLK_MHZ × TIMEOUT_US clock cycles. The defaults are 50 MHz and 128 µs, which gives 6400 cycles.
- R5: If `dtack_n` goes to 0 on the d-th clock after the strobes, with d < LIMIT, no bus error is raised for that transfer. This holds even if `dtack_n` returns high while the strobes stay low.
- R6: If `dtack_n` falls exactly on clock LIMIT after the strobes, the acknowledge wins and no bus error is raised.
- R7: Suppose the strobes go low just before rising edge 1 and no acknowledge arrives within LIMIT clocks. Then `berr_n` is still 1 after edge LIMIT+2 and goes to 0 on edge LIMIT+3. This accounts for two synchronizer flops plus the registered state.
- R8: Once low, `berr_n` stays 0 while any of `as_n`, `ds0_n` or `ds1_n` is 0. It returns to 1 on the third rising edge after all three are high.
- R9: The cycle count restarts for every transfer. Back-to-back transfers, including one the master abandons before an acknowledge, are each timed from zero.
- R10: A transfer that uses only `ds1_n` is timed the same way as one using `ds0_n` or both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds0_n | input | 1 | First data strobe, active low, asynchronous |
| ds1_n | input | 1 | Second data strobe, active low, asynchronous |
| dtack_n | input | 1 | Slave acknowledge, active low, asynchronous |
| berr_n | output | 1 | Bus error, active low |

## Verification
Every input reaches the state register three rising edges after it changes. As a result, `berr_n` falls LIMIT+3 edges after the strobes go low and rises 3 edges after they are released. A tie between the acknowledge and the limit resolves on edge LIMIT+3.

The bench drives inputs on falling edges and counts rising edges. Its driver turns each transfer into expected `berr_n` values tagged with an exact edge number. The monitor compares at the falling edge that follows that rising edge. For error cases it checks one edge early as well as on the due edge, so a result that arrives one cycle early or late is caught.

// File: rtl/bto_pkg.sv
package bto_pkg;

    // Synchronized bus lines, converted to active-high "asserted" form.
    typedef struct packed {
        logic as;
        logic ds0;
        logic ds1;
        logic dtk;
    } bto_bus_t;

    localparam int unsigned BUS_LINES = $bits(bto_bus_t);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TIMING = 2'd1,
        ST_ACKED  = 2'd2,
        ST_ERROR  = 2'd3
    } bto_state_e;

    function automatic int unsigned limit_cycles(input int unsigned mhz,
                                                 input int unsigned us);
        return mhz * us;
    endfunction

    function automatic int unsigned count_width(input int unsigned lim);
        return (lim > 1) ? $clog2(lim) : 1;
    endfunction

    function automatic logic xfer_active(input bto_bus_t b);
        return b.as & (b.ds0 | b.ds1);
    endfunction

    function automatic logic strobes_free(input bto_bus_t b);
        return ~(b.as | b.ds0 | b.ds1);
    endfunction

endpackage

// File: rtl/bto_sync.sv
module bto_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
                // R7: each stage adds exactly one cycle of delay
                a_r7_stage_delay: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> stg[s] == $past(stg[s-1]));
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/bto_timer.sv
module bto_timer #(
    parameter int unsigned LIMIT = 6400,
    parameter int unsigned CW    = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic at_limit
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (!at_limit)   cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == CW'(LIMIT - 1));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT - 1));

    // R9: every transfer starts counting from zero
    a_r9_fresh_count: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> cnt == '0);

endmodule

// File: rtl/bto_ctrl.sv
module bto_ctrl
    import bto_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bto_bus_t bus,
    input  logic     at_limit,
    output logic     timing,
    output logic     err
);

    bto_state_e st, st_nxt;
    logic       active, free;

    assign active = xfer_active(bus);
    assign free   = strobes_free(bus);

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (active) st_nxt = ST_TIMING;
            ST_TIMING: begin
                if (free)          st_nxt = ST_IDLE;
                else if (bus.dtk)  st_nxt = ST_ACKED;
                else if (at_limit) st_nxt = ST_ERROR;
            end
            ST_ACKED:  if (free) st_nxt = ST_IDLE;
            ST_ERROR:  if (free) st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    assign timing = (st == ST_TIMING);
    assign err    = (st == ST_ERROR);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> !err);

    a_r2_start_needs_strobes: assert property (@(posedge clk) disable iff (rst)
        $rose(timing) |-> $past(active));

    a_r7_err_after_limit: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(timing && at_limit));

    a_r6_ack_wins: assert property (@(posedge clk) disable iff (rst)
        (timing && bus.dtk) |=> !err);

    a_r8_err_held: assert property (@(posedge clk) disable iff (rst)
        (err && !free) |=> err);

    a_r8_err_released: assert property (@(posedge clk) disable iff (rst)
        (err && free) |=> !err);

endmodule

// File: rtl/bto_monitor.sv
module bto_monitor
    import bto_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 50,
    parameter int unsigned TIMEOUT_US = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic as_n,
    input  logic ds0_n,
    input  logic ds1_n,
    input  logic dtack_n,
    output logic berr_n
);

    localparam int unsigned LIMIT = limit_cycles(CLK_MHZ, TIMEOUT_US);
    localparam int unsigned CW    = count_width(LIMIT);

    bto_bus_t raw_bus, sync_bus;
    logic     timing, at_limit, err;

    assign raw_bus = '{as: ~as_n, ds0: ~ds0_n, ds1: ~ds1_n, dtk: ~dtack_n};

    bto_sync #(
        .WIDTH  (BUS_LINES),
        .STAGES (2)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_bus),
        .q_sync  (sync_bus)
    );

    bto_timer #(
        .LIMIT (LIMIT),
        .CW    (CW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (timing),
        .at_limit (at_limit)
    );

    bto_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .bus      (sync_bus),
        .at_limit (at_limit),
        .timing   (timing),
        .err      (err)
    );

    assign berr_n = ~err;

    // R3: with strobes free, the block cannot be timing
    a_r3_idle_not_timed: assert property (@(posedge clk) disable iff (rst)
        strobes_free(sync_bus) |=> !timing);

endmodule

// File: tb/bto_monitor_tb.sv
module bto_monitor_tb;

    localparam int LIMIT = 50 * 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, dtack_n = 1'b1;
    logic berr_n;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int    q_cyc[$];
    logic  q_val[$];
    string q_tag[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bto_monitor u_dut (
        .clk     (clk),
        .rst     (rst),
        .as_n    (as_n),
        .ds0_n   (ds0_n),
        .ds1_n   (ds1_n),
        .dtack_n (dtack_n),
        .berr_n  (berr_n)
    );

    task automatic expect_at(input int at, input logic v, input string tag);
        q_cyc.push_back(at);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    // Monitor: pops expectations when their edge count is reached
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            n_chk++;
            if (q_cyc[0] < cyc) begin
                n_fail++;
                $display("FAIL %s: check at edge %0d missed (now %0d), actual %b expected %b",
                         q_tag[0], q_cyc[0], cyc, berr_n, q_val[0]);
            end else if (berr_n !== q_val[0]) begin
                n_fail++;
                $display("FAIL %s: edge %0d berr_n actual %b expected %b",
                         q_tag[0], cyc, berr_n, q_val[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_val.pop_front());
            void'(q_tag.pop_front());
        end
    end

    // Driver: one transfer; ack_at < 0 means no acknowledge
    task automatic xfer(input logic a, input logic d0, input logic d1,
                        input int ack_at, input int ack_len, input int hold,
                        input string tag);
        int  c;
        bit  valid, err;
        @(negedge clk);
        c     = cyc;
        valid = (a == 1'b0) && (d0 == 1'b0 || d1 == 1'b0);
        err   = valid && (ack_at < 0 || ack_at > LIMIT) && (hold > LIMIT + 3);
        if (err) begin
            expect_at(c + LIMIT + 2, 1'b1, tag);
            expect_at(c + LIMIT + 3, 1'b0, tag);
            expect_at(c + hold + 2, 1'b0, {tag, " R8 held"});
            expect_at(c + hold + 3, 1'b1, {tag, " R8 release"});
        end else begin
            expect_at((hold > LIMIT + 3) ? c + LIMIT + 3 : c + hold, 1'b1, tag);
            expect_at(c + hold + 3, 1'b1, tag);
        end
        as_n  = a;
        ds0_n = d0;
        ds1_n = d1;
        for (int k = 1; k <= hold; k++) begin
            @(negedge clk);
            if (k == ack_at) dtack_n = 1'b0;
            if (ack_len > 0 && k == ack_at + ack_len) dtack_n = 1'b1;
        end
        as_n = 1'b1; ds0_n = 1'b1; ds1_n = 1'b1; dtack_n = 1'b1;
    endtask

    task automatic idle(input int n, input string tag);
        int c;
        @(negedge clk);
        c = cyc;
        expect_at(c + n, 1'b1, tag);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (berr_n !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: berr_n in reset actual %b expected 1", berr_n);
        end
        rst = 1'b0;
        idle(2, "R1 after reset");

        // Long idle, like waiting for bus ownership, then a full-budget transfer
        idle(3 * LIMIT, "R3 idle never counts");
        xfer(0, 0, 1, LIMIT - 2, 0, LIMIT + 20, "R3 R5 near-limit ack after idle");

        xfer(0, 0, 1, 10, 0, LIMIT + 20, "R5 early ack ds0");
        xfer(0, 0, 0, 30, 5, LIMIT + 20, "R5 ack released early");
        xfer(0, 0, 0, -1, 0, LIMIT + 40, "R4 R7 no ack both strobes");
        xfer(0, 1, 0, -1, 0, LIMIT + 20, "R10 R7 ds1 only");
        xfer(0, 0, 0, LIMIT, 0, LIMIT + 20, "R6 tie ack wins");
        xfer(0, 0, 1, LIMIT + 1, 0, LIMIT + 20, "R7 ack one late");
        xfer(0, 1, 1, -1, 0, 2 * LIMIT, "R2 address strobe alone");
        xfer(1, 0, 0, -1, 0, 2 * LIMIT, "R2 data strobes alone");

        // Back-to-back transfers each timed on their own
        xfer(0, 0, 0, (LIMIT * 3) / 4, 0, (LIMIT * 3) / 4 + 5, "R9 first");
        xfer(0, 0, 0, (LIMIT * 3) / 4, 0, (LIMIT * 3) / 4 + 5, "R9 second");
        xfer(0, 0, 0, -1, 0, LIMIT / 2, "R9 abandoned");
        xfer(0, 0, 0, LIMIT - 1, 0, LIMIT + 20, "R9 after abandon");

        // Error held while only the address strobe remains low
        begin
            int c;
            @(negedge clk);
            c = cyc;
            expect_at(c + LIMIT + 3, 1'b0, "R7 partial release");
            expect_at(c + LIMIT + 40 + 5, 1'b0, "R8 held by address strobe");
            expect_at(c + LIMIT + 80 + 2, 1'b0, "R8 held until edge 3");
            expect_at(c + LIMIT + 80 + 3, 1'b1, "R8 release");
            as_n = 1'b0; ds0_n = 1'b0;
            repeat (LIMIT + 40) @(negedge clk);
            ds0_n = 1'b1;
            repeat (40) @(negedge clk);
            as_n = 1'b1;
        end
        idle(20, "R8 quiet after release");

        while (q_cyc.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule